// File: doc/BRIEF.md
# Central Bus Arbiter with Selectable Allocation and Release Policies

This block decides which of N bus masters owns a shared bus. Every master drives its own request line and receives its own grant line, so the arbiter sees all requests at once and gives out at most one grant. A master may drive the bus only while its grant is high. The owner signals each finished transaction on its own done line. The arbiter then decides whether the bus moves on, following two run-time mode inputs. The first picks how a winner is chosen: fixed priority, where the lowest index always wins, or rotating priority, where a search pointer moves past each newly granted master. The second picks when an owner gives up the bus: after every transaction, or only at a transaction boundary where another master is waiting.

Two mechanisms take the bus away from an unfinished transaction. One is a preempt input. The other is a per-master wait counter: when a waiting request reaches a programmable limit, the owner is forced off and that master wins the next arbitration, whatever the priority order. A handover always passes through one cycle with no grant. The master that was just released is left out of the following arbitration whenever some other master is requesting.

Top module: `bus_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle.
- R2: A grant bit is high only if that master's request was high at the previous clock edge. The owner loses its grant at the edge where its request is seen low.
- R3: With `rotate_mode_i` = 0 (fixed priority), an arbitration grants the lowest-indexed eligible requester. A higher-priority arrival does not take the bus from the current owner.
- R4: With `rotate_mode_i` = 1, an arbitration grants the first eligible requester found by searching upward from the pointer, wrapping from N-1 to 0. After each grant the pointer moves to the winner's index plus one.
- R5: With `hold_mode_i` = 0 (per-transaction release), a done pulse from the owner removes its grant at that edge.
- R6: With `hold_mode_i` = 1, a done pulse from the owner removes its grant only if another master's request is high at the same edge. Otherwise the owner keeps the bus.
- R7: `preempt_i` high at an edge removes the current grant at that edge. While no master is granted, it has no effect.
- R8: When `wait_limit_i` is nonzero, a master that requests continuously while another master holds the bus is granted at the (limit+2)-th edge after its request is first seen: the owner is removed at the (limit+1)-th edge. A limit of 0 turns this bound off.
- R9: While no master requests, no grant is given and the rotation pointer does not move.
- R10: The grant never moves directly from one master to another: every handover includes at least one cycle with `gnt_o` = 0. A new grant appears one edge after the release.
- R11: The master whose grant was last removed is left out of the next arbitration unless it is the only requester.
- R12: While `rst_n` is low at an edge, `gnt_o` is all zeros after that edge. The pointer returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N | Per-master bus request |
| done_i | input | N | Per-master transaction-complete pulse |
| preempt_i | input | 1 | Force the current owner off the bus |
| rotate_mode_i | input | 1 | 0 = fixed priority, 1 = rotating priority |
| hold_mode_i | input | 1 | 0 = release after each transaction, 1 = release only on demand |
| wait_limit_i | input | CW | Maximum wait in cycles before a forced grant; 0 disables |
| gnt_o | output | N | Per-master grant, one-hot or zero |

## Verification
The bench builds the arbiter with N = 4 and CW = 4. Four masters are enough for the rotating pointer to wrap past the top index. They also let a released master, a higher-priority newcomer and a distant waiter all be present in the same sequence. A 4-bit limit keeps the forced-grant window short, so the bench can count the exact edge of the release and of the new grant. It also runs the same scenario with the bound turned off and checks that the owner keeps the bus.

// File: rtl/arb_pkg.sv
// Package: shared policy encodings for the bus arbiter.
// Assumes: the top module maps its single-bit mode inputs onto these types.
package arb_pkg;

    // How a winner is chosen among eligible requesters
    typedef enum logic {
        ALLOC_FIXED  = 1'b0,
        ALLOC_ROTATE = 1'b1
    } alloc_e;

    // When the current owner gives up the bus
    typedef enum logic {
        REL_PER_TXN   = 1'b0,
        REL_ON_DEMAND = 1'b1
    } release_e;

endpackage

// File: rtl/arb_wait_track.sv
// Module: arb_wait_track
// Counts, for each master, the consecutive cycles its request has waited
// without a grant. It flags the master as urgent once the count reaches a
// nonzero limit.
// Assumes: gnt_i is the arbiter's registered grant vector; a limit of 0
// disables the urgency flags.
module arb_wait_track #(
    parameter int N  = 4,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  gnt_i,
    input  logic [CW-1:0] limit_i,
    output logic [N-1:0]  urgent_o
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [CW-1:0] wait_q;

        // Count waiting cycles; clear on grant or withdrawn request, saturate
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wait_q <= '0;
            end else if (!req_i[g] || gnt_i[g]) begin
                wait_q <= '0;
            end else if (wait_q != CNT_MAX) begin
                wait_q <= wait_q + 1'b1;
            end
        end

        // Flag the master once its wait reaches the enabled limit
        always_comb begin
            urgent_o[g] = req_i[g] && (limit_i != '0) && (wait_q >= limit_i);
        end
    end

endmodule

// File: rtl/arb_select.sv
// Module: arb_select
// Combinational winner selection. Urgent masters come first (lowest index).
// Otherwise the candidates are picked by fixed priority (index 0 highest) or
// by a rotating search that starts at the pointer.
// Assumes: N >= 2; excl_idx_i names the master released last, which is
// dropped from the candidates unless it is the only requester.
module arb_select
    import arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  urgent_i,
    input  logic          excl_vld_i,
    input  logic [IW-1:0] excl_idx_i,
    input  logic [IW-1:0] ptr_i,
    input  alloc_e        alloc_i,
    output logic          win_vld_o,
    output logic [IW-1:0] win_idx_o
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] excl_oh;
    logic [N-1:0] cand;
    logic [IW-1:0] fixed_idx;
    logic [IW-1:0] rot_idx;
    logic [IW-1:0] urg_idx;

    // Build the candidate set with the last owner set aside when others wait
    always_comb begin
        excl_oh = excl_vld_i ? (ONE << excl_idx_i) : '0;
        cand    = req_i;
        if ((req_i & ~excl_oh) != '0) begin
            cand = req_i & ~excl_oh;
        end
    end

    // Lowest-indexed candidate for fixed priority
    always_comb begin
        fixed_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) fixed_idx = IW'(i);
        end
    end

    // First candidate at or above the pointer, wrapping, for rotating priority
    always_comb begin
        rot_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int pos;
            pos = int'(ptr_i) + k;
            if (pos >= N) pos = pos - N;
            if (cand[pos]) rot_idx = IW'(pos);
        end
    end

    // Lowest-indexed urgent master overrides either policy
    always_comb begin
        urg_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (urgent_i[i]) urg_idx = IW'(i);
        end
    end

    // Final choice
    always_comb begin
        win_vld_o = |cand;
        if (urgent_i != '0) begin
            win_idx_o = urg_idx;
        end else if (alloc_i == ALLOC_ROTATE) begin
            win_idx_o = rot_idx;
        end else begin
            win_idx_o = fixed_idx;
        end
    end

endmodule

// File: rtl/arb_owner.sv
// Module: arb_owner
// Holds the current owner of the bus, decides when it must release, records
// the released master and advances the rotation pointer on each grant.
// Assumes: a release and a new grant never fall on the same edge, so every
// handover passes through one cycle without an owner.
module arb_owner
    import arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  done_i,
    input  logic [N-1:0]  urgent_i,
    input  logic          preempt_i,
    input  release_e      release_i,
    input  logic          win_vld_i,
    input  logic [IW-1:0] win_idx_i,
    output logic [N-1:0]  gnt_o,
    output logic          excl_vld_o,
    output logic [IW-1:0] excl_idx_o,
    output logic [IW-1:0] ptr_o
);

    localparam logic [N-1:0]  ONE     = {{(N-1){1'b0}}, 1'b1};
    localparam logic [IW-1:0] LAST_IX = IW'(N - 1);

    logic          own_vld_q;
    logic [IW-1:0] own_idx_q;
    logic          last_vld_q;
    logic [IW-1:0] last_idx_q;
    logic [IW-1:0] ptr_q;
    logic [N-1:0]  own_oh;
    logic          others_req;
    logic          owner_done;
    logic          release_now;

    // Decode the owner and evaluate every reason to give up the bus
    always_comb begin
        own_oh      = own_vld_q ? (ONE << own_idx_q) : '0;
        others_req  = (req_i & ~own_oh) != '0;
        owner_done  = (done_i & own_oh) != '0;
        release_now = own_vld_q && (
                          preempt_i
                       || ((req_i & own_oh) == '0)
                       || ((urgent_i & ~own_oh) != '0)
                       || (owner_done && (release_i == REL_PER_TXN || others_req)));
    end

    // Ownership, last-released record and rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_vld_q  <= 1'b0;
            own_idx_q  <= '0;
            last_vld_q <= 1'b0;
            last_idx_q <= '0;
            ptr_q      <= '0;
        end else if (release_now) begin
            own_vld_q  <= 1'b0;
            last_vld_q <= 1'b1;
            last_idx_q <= own_idx_q;
        end else if (!own_vld_q && win_vld_i) begin
            own_vld_q  <= 1'b1;
            own_idx_q  <= win_idx_i;
            last_vld_q <= 1'b0;
            ptr_q      <= (win_idx_i == LAST_IX) ? '0 : win_idx_i + 1'b1;
        end
    end

    // Drive outputs from registered state
    always_comb begin
        gnt_o      = own_oh;
        excl_vld_o = last_vld_q;
        excl_idx_o = last_idx_q;
        ptr_o      = ptr_q;
    end

endmodule

// File: rtl/bus_arbiter.sv
// Module: bus_arbiter (top)
// Central arbiter for N masters, each with a dedicated request and grant.
// Allocation (fixed or rotating) and release (per transaction or on demand)
// are chosen at run time. A preempt input and a per-master wait bound force
// the owner off the bus.
// Assumes: N >= 2; masters keep their request high for as long as they want
// the bus and pulse done for one cycle when a transaction ends.
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  done_i,
    input  logic          preempt_i,
    input  logic          rotate_mode_i,
    input  logic          hold_mode_i,
    input  logic [CW-1:0] wait_limit_i,
    output logic [N-1:0]  gnt_o
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    alloc_e        alloc_sel;
    release_e      release_sel;
    logic [N-1:0]  urgent;
    logic [N-1:0]  gnt;
    logic          excl_vld;
    logic [IW-1:0] excl_idx;
    logic [IW-1:0] ptr;
    logic          win_vld;
    logic [IW-1:0] win_idx;

    // Map the mode pins onto the policy types
    always_comb begin
        alloc_sel   = rotate_mode_i ? ALLOC_ROTATE : ALLOC_FIXED;
        release_sel = hold_mode_i ? REL_ON_DEMAND : REL_PER_TXN;
    end

    arb_wait_track #(.N(N), .CW(CW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .gnt_i    (gnt),
        .limit_i  (wait_limit_i),
        .urgent_o (urgent)
    );

    arb_select #(.N(N), .IW(IW)) u_select (
        .req_i      (req_i),
        .urgent_i   (urgent),
        .excl_vld_i (excl_vld),
        .excl_idx_i (excl_idx),
        .ptr_i      (ptr),
        .alloc_i    (alloc_sel),
        .win_vld_o  (win_vld),
        .win_idx_o  (win_idx)
    );

    arb_owner #(.N(N), .IW(IW)) u_owner (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .done_i     (done_i),
        .urgent_i   (urgent),
        .preempt_i  (preempt_i),
        .release_i  (release_sel),
        .win_vld_i  (win_vld),
        .win_idx_i  (win_idx),
        .gnt_o      (gnt),
        .excl_vld_o (excl_vld),
        .excl_idx_o (excl_idx),
        .ptr_o      (ptr)
    );

    // Grant output
    always_comb begin
        gnt_o = gnt;
    end

endmodule

// File: rtl/bus_arbiter_chk.sv
// Module: bus_arbiter_chk
// Property checker for bus_arbiter, attached through bind. It observes ports only.
module bus_arbiter_chk #(
    parameter int N  = 4,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  req_i,
    input logic [N-1:0]  done_i,
    input logic          preempt_i,
    input logic          hold_mode_i,
    input logic [N-1:0]  gnt_o
);

    // R1: one grant at most
    a_r1_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R2: a grant needs a request seen at the previous edge
    for (genvar g = 0; g < N; g++) begin : g_req
        a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[g] |-> $past(req_i[g]));
    end

    // R5: per-transaction release after done
    a_r5_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_mode_i && ((gnt_o & done_i) != '0)) |=> (gnt_o == '0));

    // R7: preemption clears the grant
    a_r7_preempt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (preempt_i && (gnt_o != '0)) |=> (gnt_o == '0));

    // R10: no direct hand-over between two masters
    a_r10_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o != '0) && ($past(gnt_o) != '0)) |-> (gnt_o == $past(gnt_o)));

    // R12: reset clears the grants
    a_r12_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (gnt_o == '0));

endmodule

bind bus_arbiter bus_arbiter_chk #(.N(N), .CW(CW)) u_bus_arbiter_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .done_i      (done_i),
    .preempt_i   (preempt_i),
    .hold_mode_i (hold_mode_i),
    .gnt_o       (gnt_o)
);

// File: tb/test_bus_arbiter.sv
module test_bus_arbiter;

    localparam int N    = 4;
    localparam int CW   = 4;
    localparam int NVEC = 29;

    // Vector layout: req[14:11] done[10:7] preempt[6] rotate[5] hold[4] expected gnt[3:0]
    localparam logic [14:0] VEC [NVEC] = '{
        {4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000}, // 0  R9 idle
        {4'b0110, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0010}, // 1  R3 lowest of 1,2
        {4'b0111, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0010}, // 2  R3 no takeover
        {4'b0111, 4'b0010, 1'b0, 1'b0, 1'b0, 4'b0000}, // 3  R5 done releases
        {4'b0111, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0001}, // 4  R11 master 1 skipped
        {4'b0111, 4'b0001, 1'b0, 1'b0, 1'b0, 4'b0000}, // 5  R5
        {4'b0110, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0010}, // 6  R3
        {4'b0110, 4'b0010, 1'b0, 1'b0, 1'b0, 4'b0000}, // 7  R5
        {4'b0010, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0010}, // 8  R11 sole requester
        {4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000}, // 9  R2 request dropped
        {4'b1011, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b1000}, // 10 R4 pointer at 2
        {4'b1011, 4'b1000, 1'b0, 1'b1, 1'b0, 4'b0000}, // 11 R5
        {4'b1011, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0001}, // 12 R4 wrap to 0
        {4'b1011, 4'b0001, 1'b0, 1'b1, 1'b0, 4'b0000}, // 13 R10 gap
        {4'b1011, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0010}, // 14 R4
        {4'b1011, 4'b0010, 1'b0, 1'b1, 1'b0, 4'b0000}, // 15 R10 gap
        {4'b1011, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b1000}, // 16 R4 skip absent 2
        {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0000}, // 17 R2
        {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0000}, // 18 R9
        {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0000}, // 19 R9
        {4'b0100, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0100}, // 20 R9 pointer still 0
        {4'b0100, 4'b0100, 1'b0, 1'b1, 1'b1, 4'b0100}, // 21 R6 keep, nobody else
        {4'b0101, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0100}, // 22 R6 no done yet
        {4'b0101, 4'b0100, 1'b0, 1'b1, 1'b1, 4'b0000}, // 23 R6 done with waiter
        {4'b0101, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0001}, // 24 R4 pointer 3 wraps
        {4'b0101, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b0000}, // 25 R7 preempt
        {4'b0101, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0100}, // 26 R11 after preempt
        {4'b0100, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0100}, // 27 R6 hold
        {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0000}  // 28 R2
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req;
    logic [N-1:0]  done;
    logic          preempt;
    logic          rotate;
    logic          hold;
    logic [CW-1:0] limit;
    logic [N-1:0]  gnt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_arbiter #(.N(N), .CW(CW)) i_bus_arbiter (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .done_i        (done),
        .preempt_i     (preempt),
        .rotate_mode_i (rotate),
        .hold_mode_i   (hold),
        .wait_limit_i  (limit),
        .gnt_o         (gnt)
    );

    function automatic string tag_of(int i);
        case (i)
            0, 18, 19, 20:           return "R9";
            1, 2, 6:                 return "R3";
            3, 5, 7, 11:             return "R5";
            4, 8, 26:                return "R11";
            9, 17, 28:               return "R2";
            10, 12, 14, 16, 24:      return "R4";
            13, 15:                  return "R10";
            21, 22, 23, 27:          return "R6";
            default:                 return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [N-1:0] exp);
        checks++;
        if (gnt !== exp) begin
            errors++;
            $display("FAIL %s: gnt actual %b expected %b at %0t", tag, gnt, exp, $time);
        end
    endtask

    // One edge, then settle away from it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; req = '0; done = '0; preempt = 1'b0;
        rotate = 1'b0; hold = 1'b0; limit = '0;
        tick();
        tick();
        check("R12", 4'b0000);   // reset state
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            req     = VEC[v][14:11];
            done    = VEC[v][10:7];
            preempt = VEC[v][6];
            rotate  = VEC[v][5];
            hold    = VEC[v][4];
            tick();
            check(tag_of(v), VEC[v][3:0]);
        end
        done = '0; preempt = 1'b0; req = '0;

        // R7: preempt with no owner is ignored
        tick();
        preempt = 1'b1;
        tick();
        check("R7", 4'b0000);
        preempt = 1'b0;
        req = 4'b1000;
        tick();
        check("R7", 4'b1000);

        // R12: reset while a master owns the bus
        rst_n = 1'b0;
        tick();
        check("R12", 4'b0000);
        rst_n = 1'b1;
        req = '0;
        tick();

        // R8: wait bound of 3, demand release, owner never finishes
        do_reset();
        rotate = 1'b0; hold = 1'b1; limit = 4'd3;
        req = 4'b0001;
        tick();
        check("R8", 4'b0001);
        req = 4'b1001;
        tick(); tick(); tick();
        check("R8", 4'b0001);    // three edges: still held
        tick();
        check("R8", 4'b0000);    // limit+1: forced release
        tick();
        check("R8", 4'b1000);    // limit+2: waiter granted
        req = '0;
        tick();
        tick();

        // R8: limit 0 disables the bound
        do_reset();
        limit = '0;
        req = 4'b0001;
        tick();
        req = 4'b1001;
        for (int k = 0; k < 20; k++) tick();
        check("R8", 4'b0001);
        req = '0;
        tick();
        check("R2", 4'b0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule